// File: doc/BRIEF.md
# Sorted Memory Trace Consistency Checker

This block watches a stream of memory-access rows that a producer has already sorted, first by word address and then by step number within each address. Each row carries a word address, a step number, an operation bit, a write bit, a word value split into eight limbs, and a "group end" bit. The group end bit says that the next row moves on to a different address. The checker confirms three things. The ordering is legal. Every row that is not a write repeats the word held by the row before it. The first row seen for an address that is not a write reads as all-zero, since untouched memory holds zero.

One row is taken in each cycle in which `row_valid` is high, and `row_last` marks the closing row of a trace. Each row is checked against the row held before it. When the closing row arrives, the checker also evaluates one extra transition that wraps from that closing row back to the first row of the trace. Every rule class has its own error flag, and each flag stays set until a synchronous clear. One cycle after the closing row, a done pulse appears together with an overall pass verdict.

Top module: `mem_trace_checker`

## Requirements
- R1: A row with write bit 1 and operation bit 0 sets `err_flag` in the cycle after the row is taken. A row is a write only when both bits are 1.
- R2: If the held row has group end 0, the next row must carry the same address, otherwise `err_order` is set.
- R3: Within one address, the next step minus the held step, taken as an unsigned difference, must lie in 1..TRACE_LEN, otherwise `err_order` is set. An equal step, a smaller step or a gap above TRACE_LEN are all errors.
- R4: If the held row has group end 1, the next address minus the held address must lie in 1..TRACE_LEN, otherwise `err_order` is set.
- R5: If the next row is not a write and the held row has group end 0, all eight limbs of the next row must equal those of the held row, otherwise `err_value` is set.
- R6: If the next row is not a write and the held row has group end 1, all eight limbs of the next row must be zero, otherwise `err_value` is set.
- R7: A write row may carry any value without raising `err_value`.
- R8: A closing row (`row_last` = 1) with group end 0 sets `err_final`.
- R9: On the closing row, the closing row is treated as held and the first row of the trace as next, and the R5/R6 value rules are applied to that pair. No ordering check is made on this wrap pair. A one-row trace wraps onto itself.
- R10: `done` is high for exactly the one cycle after a closing row. `pass` is updated at that same cycle: it goes to 1 when no error flag is set and to 0 otherwise. After that, `pass` holds until a clear, or until a later error sets a flag, which drops it to 0.
- R11: Error flags are sticky. `clr` drives every output to 0 on the next cycle and discards the held rows.
- R12: The row after a closing row starts a new trace. It is not checked against the previous trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of all state and outputs |
| row_valid | input | 1 | A row is presented this cycle |
| row_last | input | 1 | The presented row closes the trace |
| row_addr | input | ADDR_W | Word address |
| row_step | input | STEP_W | Step number |
| row_op | input | 1 | Operation bit |
| row_wr | input | 1 | Write bit |
| row_lastacc | input | 1 | Group end: the next row has a different address |
| row_val | input | LIMBS*LIMB_W | Word value, limb k at bits [k*LIMB_W +: LIMB_W] |
| err_order | output | 1 | Sticky ordering error |
| err_flag | output | 1 | Sticky flag legality error |
| err_value | output | 1 | Sticky value consistency error |
| err_final | output | 1 | Sticky missing group end on the closing row |
| done | output | 1 | One-cycle pulse after a closing row |
| pass | output | 1 | Verdict for the most recently closed trace |

## Verification
The assertions assume that `clr` takes priority over any row presented in the same cycle. They also assume that the row fields are stable and meaningful whenever `row_valid` is high. The implication properties fire only when a row is taken with `clr` low. The stimulus therefore presents rows only on negative clock edges, one row per pulse of `row_valid`, and always drops `clr` before the next row is driven. Traces are kept short, and `TRACE_LEN` is set to 16 so that both edges of the step and address windows can be reached.

// File: rtl/mtc_pkg.sv
`timescale 1ns/1ps
package mtc_pkg;

  // Unsigned forward distance from cur to nxt must be in 1..lim.
  function automatic logic in_window(input logic [63:0] nxt,
                                     input logic [63:0] cur,
                                     input logic [63:0] lim);
    logic [63:0] d;
    d = nxt - cur;
    return (d != 64'd0) && (d <= lim);
  endfunction

  // A row counts as a write only when both bits are set.
  function automatic logic row_is_write(input logic op, input logic wr);
    return op & wr;
  endfunction

  // The write bit may be set only together with the operation bit.
  function automatic logic flags_illegal(input logic op, input logic wr);
    return wr & ~op;
  endfunction

  // Value rule: writes are free, otherwise continue or start at zero.
  function automatic logic value_legal(input logic nxt_write,
                                       input logic continuing,
                                       input logic equal,
                                       input logic nxt_zero);
    return nxt_write | (continuing ? equal : nxt_zero);
  endfunction

endpackage

// File: rtl/mtc_row_store.sv
`timescale 1ns/1ps
module mtc_row_store #(
  parameter int ADDR_W = 32,
  parameter int STEP_W = 32,
  parameter int VAL_W  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic              row_last,
  input  logic [ADDR_W-1:0] row_addr,
  input  logic [STEP_W-1:0] row_step,
  input  logic              row_op,
  input  logic              row_wr,
  input  logic              row_lastacc,
  input  logic [VAL_W-1:0]  row_val,
  output logic              have_prev,
  output logic [ADDR_W-1:0] prev_addr,
  output logic [STEP_W-1:0] prev_step,
  output logic              prev_lastacc,
  output logic [VAL_W-1:0]  prev_val,
  output logic              first_op,
  output logic              first_wr,
  output logic [VAL_W-1:0]  first_val
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev    <= 1'b0;
      prev_addr    <= '0;
      prev_step    <= '0;
      prev_lastacc <= 1'b0;
      prev_val     <= '0;
      first_op     <= 1'b0;
      first_wr     <= 1'b0;
      first_val    <= '0;
    end else if (clr) begin
      have_prev    <= 1'b0;
    end else if (take) begin
      prev_addr    <= row_addr;
      prev_step    <= row_step;
      prev_lastacc <= row_lastacc;
      prev_val     <= row_val;
      if (!have_prev) begin
        first_op   <= row_op;
        first_wr   <= row_wr;
        first_val  <= row_val;
      end
      // the closing row ends the trace; the next row starts fresh
      have_prev    <= ~row_last;
    end
  end

  // R12: nothing is held across a trace boundary
  a_r12_fresh_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (take && row_last && !clr) |=> !have_prev);

endmodule

// File: rtl/mtc_limb_cmp.sv
`timescale 1ns/1ps
module mtc_limb_cmp #(
  parameter int LIMBS  = 8,
  parameter int LIMB_W = 32,
  localparam int VAL_W = LIMBS * LIMB_W
) (
  input  logic [VAL_W-1:0] nxt_val,
  input  logic [VAL_W-1:0] ref_val,
  output logic             all_equal,
  output logic             nxt_zero
);

  logic [LIMBS-1:0] limb_eq;
  logic [LIMBS-1:0] limb_zero;

  for (genvar k = 0; k < LIMBS; k++) begin : g_limb
    assign limb_eq[k]   = (nxt_val[k*LIMB_W +: LIMB_W] == ref_val[k*LIMB_W +: LIMB_W]);
    assign limb_zero[k] = (nxt_val[k*LIMB_W +: LIMB_W] == '0);
  end

  assign all_equal = &limb_eq;
  assign nxt_zero  = &limb_zero;

endmodule

// File: rtl/mtc_order_rules.sv
`timescale 1ns/1ps
module mtc_order_rules
  import mtc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int STEP_W    = 32,
  parameter int TRACE_LEN = 1024
) (
  input  logic [ADDR_W-1:0] prev_addr,
  input  logic [STEP_W-1:0] prev_step,
  input  logic              prev_lastacc,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [STEP_W-1:0] cur_step,
  output logic              same_addr_ok,
  output logic              step_ok,
  output logic              addr_ok,
  output logic              order_ok
);

  localparam logic [63:0] LIM = 64'(TRACE_LEN);

  assign same_addr_ok = (cur_addr == prev_addr);
  assign step_ok      = in_window(64'(cur_step), 64'(prev_step), LIM);
  assign addr_ok      = in_window(64'(cur_addr), 64'(prev_addr), LIM);
  assign order_ok     = prev_lastacc ? addr_ok : (same_addr_ok & step_ok);

endmodule

// File: rtl/mem_trace_checker.sv
`timescale 1ns/1ps
module mem_trace_checker
  import mtc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int STEP_W    = 32,
  parameter int LIMBS     = 8,
  parameter int LIMB_W    = 32,
  parameter int TRACE_LEN = 1024,
  localparam int VAL_W    = LIMBS * LIMB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              row_valid,
  input  logic              row_last,
  input  logic [ADDR_W-1:0] row_addr,
  input  logic [STEP_W-1:0] row_step,
  input  logic              row_op,
  input  logic              row_wr,
  input  logic              row_lastacc,
  input  logic [VAL_W-1:0]  row_val,
  output logic              err_order,
  output logic              err_flag,
  output logic              err_value,
  output logic              err_final,
  output logic              done,
  output logic              pass
);

  // ---------------- held rows ----------------
  logic              have_prev;
  logic [ADDR_W-1:0] prev_addr;
  logic [STEP_W-1:0] prev_step;
  logic              prev_lastacc;
  logic [VAL_W-1:0]  prev_val;
  logic              first_op_q, first_wr_q;
  logic [VAL_W-1:0]  first_val_q;

  logic row_take;
  assign row_take = row_valid & ~clr;

  mtc_row_store #(.ADDR_W(ADDR_W), .STEP_W(STEP_W), .VAL_W(VAL_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr), .take(row_take), .row_last(row_last),
    .row_addr(row_addr), .row_step(row_step), .row_op(row_op), .row_wr(row_wr),
    .row_lastacc(row_lastacc), .row_val(row_val),
    .have_prev(have_prev), .prev_addr(prev_addr), .prev_step(prev_step),
    .prev_lastacc(prev_lastacc), .prev_val(prev_val),
    .first_op(first_op_q), .first_wr(first_wr_q), .first_val(first_val_q)
  );

  // ---------------- named events ----------------
  logic trans_fire;   // a row arrives with a held predecessor
  logic final_fire;   // the closing row arrives
  assign trans_fire = row_take & have_prev;
  assign final_fire = row_take & row_last;

  // ordering of held -> current
  logic same_addr_ok, step_ok, addr_ok, order_ok;
  mtc_order_rules #(.ADDR_W(ADDR_W), .STEP_W(STEP_W), .TRACE_LEN(TRACE_LEN)) u_order (
    .prev_addr(prev_addr), .prev_step(prev_step), .prev_lastacc(prev_lastacc),
    .cur_addr(row_addr), .cur_step(row_step),
    .same_addr_ok(same_addr_ok), .step_ok(step_ok), .addr_ok(addr_ok),
    .order_ok(order_ok)
  );

  // value of held -> current
  logic t_equal, t_zero, t_value_ok;
  mtc_limb_cmp #(.LIMBS(LIMBS), .LIMB_W(LIMB_W)) u_cmp_trans (
    .nxt_val(row_val), .ref_val(prev_val), .all_equal(t_equal), .nxt_zero(t_zero)
  );
  assign t_value_ok = value_legal(row_is_write(row_op, row_wr), ~prev_lastacc,
                                  t_equal, t_zero);

  // wrap: closing row is held, first row of the trace is next
  logic             w_op, w_wr;
  logic [VAL_W-1:0] w_val;
  logic             w_equal, w_zero, w_value_ok;
  assign w_op  = have_prev ? first_op_q  : row_op;
  assign w_wr  = have_prev ? first_wr_q  : row_wr;
  assign w_val = have_prev ? first_val_q : row_val;

  mtc_limb_cmp #(.LIMBS(LIMBS), .LIMB_W(LIMB_W)) u_cmp_wrap (
    .nxt_val(w_val), .ref_val(row_val), .all_equal(w_equal), .nxt_zero(w_zero)
  );
  assign w_value_ok = value_legal(row_is_write(w_op, w_wr), ~row_lastacc,
                                  w_equal, w_zero);

  // ---------------- violations this cycle ----------------
  logic order_bad, flag_bad, value_bad, final_bad, any_new;
  assign order_bad = trans_fire & ~order_ok;
  assign flag_bad  = row_take & flags_illegal(row_op, row_wr);
  assign value_bad = (trans_fire & ~t_value_ok) | (final_fire & ~w_value_ok);
  assign final_bad = final_fire & ~row_lastacc;
  assign any_new   = order_bad | flag_bad | value_bad | final_bad;

  logic any_err_next;
  assign any_err_next = err_order | err_flag | err_value | err_final | any_new;

  // ---------------- sticky outputs ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_order <= 1'b0;
      err_flag  <= 1'b0;
      err_value <= 1'b0;
      err_final <= 1'b0;
      done      <= 1'b0;
      pass      <= 1'b0;
    end else if (clr) begin
      err_order <= 1'b0;
      err_flag  <= 1'b0;
      err_value <= 1'b0;
      err_final <= 1'b0;
      done      <= 1'b0;
      pass      <= 1'b0;
    end else begin
      err_order <= err_order | order_bad;
      err_flag  <= err_flag  | flag_bad;
      err_value <= err_value | value_bad;
      err_final <= err_final | final_bad;
      done      <= final_fire;
      if (final_fire)   pass <= ~any_err_next;
      else if (any_new) pass <= 1'b0;
    end
  end

  // ---------------- assertions ----------------
  // R1: illegal flag pair is reported
  a_r1_flag_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && !clr && row_wr && !row_op) |=> err_flag);

  // R2: a group that does not end must keep its address
  a_r2_addr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (trans_fire && !prev_lastacc && (row_addr != prev_addr)) |=> err_order);

  // R3: a repeated step inside one address is reported
  a_r3_step_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (trans_fire && !prev_lastacc && (row_step == prev_step)) |=> err_order);

  // R4: a new group may not reuse or go below the held address
  a_r4_addr_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (trans_fire && prev_lastacc && (row_addr <= prev_addr)) |=> err_order);

  // R8: closing row without group end
  a_r8_final_group: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && !clr && row_last && !row_lastacc) |=> err_final);

  // R10: done follows the closing row
  a_r10_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && !clr && row_last) |=> done);

  // R10: a pass verdict never coexists with a raised flag
  a_r10_pass_clean: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> !(err_order || err_flag || err_value || err_final));

  // R11: flags persist without clear, and clear empties everything
  a_r11_order_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_order && !clr) |=> err_order);
  a_r11_value_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_value && !clr) |=> err_value);
  a_r11_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !(err_order || err_flag || err_value || err_final || done || pass));

endmodule

// File: tb/test_mem_trace_checker.sv
`timescale 1ns/1ps
module test_mem_trace_checker;

  localparam int LIMBS  = 8;
  localparam int LIMB_W = 32;
  localparam int VAL_W  = LIMBS * LIMB_W;
  localparam int TLEN   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic row_valid = 1'b0, row_last = 1'b0;
  logic [31:0] row_addr = '0, row_step = '0;
  logic row_op = 1'b0, row_wr = 1'b0, row_lastacc = 1'b0;
  logic [VAL_W-1:0] row_val = '0;
  logic err_order, err_flag, err_value, err_final, done, pass;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  mem_trace_checker #(.TRACE_LEN(TLEN)) i_mem_trace_checker (
    .clk(clk), .rst_n(rst_n), .clr(clr), .row_valid(row_valid), .row_last(row_last),
    .row_addr(row_addr), .row_step(row_step), .row_op(row_op), .row_wr(row_wr),
    .row_lastacc(row_lastacc), .row_val(row_val),
    .err_order(err_order), .err_flag(err_flag), .err_value(err_value),
    .err_final(err_final), .done(done), .pass(pass)
  );

  // outputs as {order, flag, value, final, done, pass}
  function automatic logic [5:0] outs();
    return {err_order, err_flag, err_value, err_final, done, pass};
  endfunction

  // limb k of a short code value; code 0 means an all-zero word
  function automatic logic [VAL_W-1:0] word_of(input logic [15:0] v);
    logic [VAL_W-1:0] w;
    w = '0;
    if (v != 16'd0)
      for (int k = 0; k < LIMBS; k++) w[k*LIMB_W +: LIMB_W] = {16'h0, v} + 32'(k) * 32'h100;
    return w;
  endfunction

  task automatic chk(input int req, input logic [5:0] act, input logic [5:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL R%0d: outputs {ord,flg,val,fin,done,pass} got %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_clr();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic put_row(input logic [31:0] a, input logic [31:0] s, input logic op,
                         input logic wr, input logic la, input logic last,
                         input logic [VAL_W-1:0] v);
    @(negedge clk);
    row_valid = 1'b1; row_last = last; row_addr = a; row_step = s;
    row_op = op; row_wr = wr; row_lastacc = la; row_val = v;
    @(negedge clk);
    row_valid = 1'b0; row_last = 1'b0;
  endtask

  typedef struct packed {
    logic        c;     // clear before this row
    logic [15:0] a;
    logic [15:0] s;
    logic        op;
    logic        wr;
    logic        la;
    logic        last;
    logic [15:0] v;
    logic [5:0]  exp;   // {ord,flg,val,fin,done,pass} one cycle after the row
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 42;
  localparam vec_t TBL [NV] = '{
    // clean two-address trace
    '{1'b1, 16'd10, 16'd1,  1'b1,1'b1,1'b0,1'b0, 16'd70,   6'b000000, 4'd7},  // R7
    '{1'b0, 16'd10, 16'd2,  1'b1,1'b0,1'b0,1'b0, 16'd70,   6'b000000, 4'd5},  // R5
    '{1'b0, 16'd10, 16'd3,  1'b1,1'b1,1'b0,1'b0, 16'd80,   6'b000000, 4'd7},  // R7
    '{1'b0, 16'd10, 16'd10, 1'b1,1'b0,1'b0,1'b0, 16'd80,   6'b000000, 4'd3},  // R3
    '{1'b0, 16'd10, 16'd12, 1'b1,1'b0,1'b1,1'b0, 16'd80,   6'b000000, 4'd5},  // R5
    '{1'b0, 16'd20, 16'd4,  1'b1,1'b1,1'b0,1'b0, 16'd1000, 6'b000000, 4'd4},  // R4
    '{1'b0, 16'd20, 16'd5,  1'b1,1'b1,1'b0,1'b0, 16'd1001, 6'b000000, 4'd7},  // R7
    '{1'b0, 16'd20, 16'd8,  1'b1,1'b0,1'b0,1'b0, 16'd1001, 6'b000000, 4'd5},  // R5
    '{1'b0, 16'd20, 16'd11, 1'b1,1'b1,1'b0,1'b0, 16'd1002, 6'b000000, 4'd7},  // R7
    '{1'b0, 16'd20, 16'd18, 1'b1,1'b1,1'b1,1'b1, 16'd1003, 6'b000011, 4'd10}, // R10
    // reads from untouched words, wrap onto a zero first read
    '{1'b1, 16'd5,  16'd1,  1'b1,1'b0,1'b0,1'b0, 16'd0,    6'b000000, 4'd6},  // R6
    '{1'b0, 16'd5,  16'd2,  1'b1,1'b0,1'b1,1'b0, 16'd0,    6'b000000, 4'd5},  // R5
    '{1'b0, 16'd6,  16'd1,  1'b1,1'b0,1'b1,1'b1, 16'd0,    6'b000011, 4'd9},  // R9
    // new trace right after a closing row, lower address, no clear
    '{1'b0, 16'd1,  16'd1,  1'b1,1'b1,1'b1,1'b1, 16'd3,    6'b000011, 4'd12}, // R12
    // write bit without operation bit
    '{1'b1, 16'd1,  16'd1,  1'b0,1'b1,1'b1,1'b0, 16'd5,    6'b010000, 4'd1},  // R1
    // address change inside an open group
    '{1'b1, 16'd3,  16'd1,  1'b1,1'b1,1'b0,1'b0, 16'd7,    6'b000000, 4'd2},  // R2
    '{1'b0, 16'd4,  16'd2,  1'b1,1'b1,1'b1,1'b0, 16'd8,    6'b100000, 4'd2},  // R2
    // equal step
    '{1'b1, 16'd3,  16'd5,  1'b1,1'b1,1'b0,1'b0, 16'd7,    6'b000000, 4'd3},  // R3
    '{1'b0, 16'd3,  16'd5,  1'b1,1'b1,1'b1,1'b0, 16'd9,    6'b100000, 4'd3},  // R3
    // step gap one above the window
    '{1'b1, 16'd3,  16'd1,  1'b1,1'b1,1'b0,1'b0, 16'd7,    6'b000000, 4'd3},  // R3
    '{1'b0, 16'd3,  16'd18, 1'b1,1'b1,1'b1,1'b0, 16'd7,    6'b100000, 4'd3},  // R3
    // step gap exactly at the window
    '{1'b1, 16'd3,  16'd1,  1'b1,1'b1,1'b0,1'b0, 16'd7,    6'b000000, 4'd3},  // R3
    '{1'b0, 16'd3,  16'd17, 1'b1,1'b1,1'b1,1'b0, 16'd7,    6'b000000, 4'd3},  // R3
    // address going down across a group end
    '{1'b1, 16'd9,  16'd1,  1'b1,1'b1,1'b1,1'b0, 16'd7,    6'b000000, 4'd4},  // R4
    '{1'b0, 16'd8,  16'd2,  1'b1,1'b1,1'b1,1'b0, 16'd7,    6'b100000, 4'd4},  // R4
    // address repeated across a group end
    '{1'b1, 16'd9,  16'd1,  1'b1,1'b1,1'b1,1'b0, 16'd7,    6'b000000, 4'd4},  // R4
    '{1'b0, 16'd9,  16'd2,  1'b1,1'b1,1'b1,1'b0, 16'd7,    6'b100000, 4'd4},  // R4
    // address gap at and above the window
    '{1'b1, 16'd9,  16'd1,  1'b1,1'b1,1'b1,1'b0, 16'd7,    6'b000000, 4'd4},  // R4
    '{1'b0, 16'd25, 16'd2,  1'b1,1'b1,1'b1,1'b0, 16'd7,    6'b000000, 4'd4},  // R4
    '{1'b0, 16'd42, 16'd3,  1'b1,1'b1,1'b1,1'b0, 16'd7,    6'b100000, 4'd4},  // R4
    // read returning a different word
    '{1'b1, 16'd2,  16'd1,  1'b1,1'b1,1'b0,1'b0, 16'd11,   6'b000000, 4'd5},  // R5
    '{1'b0, 16'd2,  16'd2,  1'b1,1'b0,1'b0,1'b0, 16'd12,   6'b001000, 4'd5},  // R5
    // first read of a new address is not zero
    '{1'b1, 16'd2,  16'd1,  1'b1,1'b1,1'b1,1'b0, 16'd11,   6'b000000, 4'd6},  // R6
    '{1'b0, 16'd3,  16'd2,  1'b1,1'b0,1'b1,1'b0, 16'd4,    6'b001000, 4'd6},  // R6
    // first write of a new address may hold anything
    '{1'b1, 16'd2,  16'd1,  1'b1,1'b1,1'b1,1'b0, 16'd11,   6'b000000, 4'd7},  // R7
    '{1'b0, 16'd3,  16'd2,  1'b1,1'b1,1'b1,1'b0, 16'd4,    6'b000000, 4'd7},  // R7
    // closing row without group end
    '{1'b1, 16'd2,  16'd1,  1'b1,1'b1,1'b0,1'b1, 16'd11,   6'b000110, 4'd8},  // R8
    // wrap onto a non-zero first read
    '{1'b1, 16'd2,  16'd1,  1'b1,1'b0,1'b1,1'b0, 16'd11,   6'b000000, 4'd9},  // R9
    '{1'b0, 16'd3,  16'd2,  1'b1,1'b1,1'b1,1'b1, 16'd5,    6'b001010, 4'd9},  // R9
    // single row, open group: wrap compares the row with itself
    '{1'b1, 16'd2,  16'd1,  1'b1,1'b0,1'b0,1'b1, 16'd6,    6'b000110, 4'd9},  // R9
    // step going down
    '{1'b1, 16'd3,  16'd9,  1'b1,1'b1,1'b0,1'b0, 16'd7,    6'b000000, 4'd3},  // R3
    '{1'b0, 16'd3,  16'd4,  1'b1,1'b1,1'b1,1'b0, 16'd7,    6'b100000, 4'd3}   // R3
  };

  initial begin : watchdog
    #(20 * 150000);
    n_fails++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin : main
    logic [VAL_W-1:0] w;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(11, outs(), 6'b000000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(11, outs(), 6'b000000);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].c) do_clr();
      put_row({16'h0, TBL[i].a}, {16'h0, TBL[i].s}, TBL[i].op, TBL[i].wr,
              TBL[i].la, TBL[i].last, word_of(TBL[i].v));
      chk(int'(TBL[i].req), outs(), TBL[i].exp);
    end

    // R5: a single limb differing breaks equality
    do_clr();
    put_row(32'd7, 32'd1, 1'b1, 1'b1, 1'b0, 1'b0, word_of(16'd33));
    w = word_of(16'd33);
    w[7*LIMB_W +: LIMB_W] = w[7*LIMB_W +: LIMB_W] ^ 32'h8000_0000;
    put_row(32'd7, 32'd2, 1'b1, 1'b0, 1'b1, 1'b0, w);
    chk(5, outs(), 6'b001000);

    // R11: clear empties flags and forgets the held row
    do_clr();
    chk(11, outs(), 6'b000000);
    put_row(32'd1, 32'd1, 1'b1, 1'b1, 1'b1, 1'b1, word_of(16'd2));
    chk(11, outs(), 6'b000011);

    // R10: done lasts one cycle, pass holds while idle
    @(negedge clk);
    chk(10, outs(), 6'b000001);
    repeat (3) @(negedge clk);
    chk(10, outs(), 6'b000001);

    // R10: a later error drops a held pass; R11 the flag stays
    put_row(32'd4, 32'd1, 1'b0, 1'b1, 1'b1, 1'b0, word_of(16'd2));
    chk(10, outs(), 6'b010000);
    repeat (2) @(negedge clk);
    chk(11, outs(), 6'b010000);

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule